// File: doc/BRIEF.md
# I2C Write Target with Per-Register Data Width

This block is an I2C target that only takes writes. It samples SCL and SDA from an open-drain bus and brings both into the system clock domain. It finds start and stop conditions and compares the 7-bit device address. After the address, the first byte is a register pointer. The pointer decides whether one or two data bytes follow.

When the last data byte for a register has arrived, the block sends one write strobe to the register file, carrying the pointer, the data and a width flag. The byte after that is read as a new pointer, so a single transaction can update several registers. The pointer does not count up on its own.

The block pulls SDA low to acknowledge each byte it accepts. It never stretches the clock and never answers a read.

Top module: `i2cw_top`

## Requirements
- R1: An address byte whose upper seven bits equal `DEV_ADDR` and whose least significant bit is 0 (write) is acknowledged: `sdaPullLow` is high while SCL is high in the ninth clock. An address byte with a different address, or with the least significant bit at 1, is not acknowledged.
- R2: Every pointer byte and data byte that follows an accepted address is acknowledged in its ninth clock. `sdaPullLow` goes high only while SCL is low.
- R3: Pointers 0x01 to 0x04, 0x09 and 0x0B to 0x25 select 16-bit registers, which take two data bytes. Every other pointer value takes one byte. This includes the boundary values 0x00, 0x05, 0x08, 0x0A and 0x26.
- R4: A 16-bit register receives its most significant byte first. It is committed by a single one-cycle `wrStrobe`, with `wrData` = {first byte, second byte} and `wrWide` = 1. An 8-bit register is committed with `wrData` = {8'h00, byte} and `wrWide` = 0. `wrAddr` always carries the pointer.
- R5: Once a register's data has been committed, the next byte in the same transaction is loaded as a new pointer.
- R6: If a stop condition arrives after only the first byte of a 16-bit register, no strobe is produced and the partial value is dropped.
- R7: After an address byte that is not accepted, no later byte is acknowledged and no strobe is produced until the next start condition.
- R8: A repeated start (a start condition without a stop before it) drops any partial register. The next byte is then treated as an address byte.
- R9: After reset, `sdaPullLow` and `wrStrobe` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | SCL level as seen on the bus |
| sdaIn | input | 1 | SDA level as seen on the bus |
| sdaPullLow | output | 1 | When high, the SDA pad driver pulls the line low |
| wrStrobe | output | 1 | One-cycle pulse: a register write is complete |
| wrAddr | output | 8 | Register pointer of the write |
| wrData | output | 16 | Write data (upper byte is zero for 8-bit registers) |
| wrWide | output | 1 | 1 when the written register is 16 bits wide |

## Verification
A fault in the byte-phase state shows up within one byte time. A missing or extra acknowledge appears in the ninth clock of the affected byte. A wrong width decision shows at the next `wrStrobe`: it appears one byte too early or too late, or it carries a mis-assembled word. A pointer that was not reloaded shows as a wrong `wrAddr` on the following register of the same transaction. A stale partial value left over after a stop or a repeated start shows as an unexpected strobe, which the scoreboard flags against its queue of expected writes.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  localparam logic [7:0] WIDE_LO_A = 8'h01;
  localparam logic [7:0] WIDE_HI_A = 8'h04;
  localparam logic [7:0] WIDE_ONE  = 8'h09;
  localparam logic [7:0] WIDE_LO_B = 8'h0B;
  localparam logic [7:0] WIDE_HI_B = 8'h25;

  // Strobes from control to datapath, each valid for one clock cycle.
  typedef struct packed {
    logic loadPtr;
    logic loadMsb;
    logic commitWide;
    logic commitNarrow;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_MSB,
    ST_LSB,
    ST_BYTE,
    ST_IGNORE
  } phase_t;

  function automatic logic isWide(input logic [7:0] ptr);
    return ((ptr >= WIDE_LO_A) && (ptr <= WIDE_HI_A)) ||
           (ptr == WIDE_ONE) ||
           ((ptr >= WIDE_LO_B) && (ptr <= WIDE_HI_B));
  endfunction

endpackage

// File: rtl/i2cw_busmon.sv
module i2cw_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclChain;
  logic [LAST:0] sdaChain;
  logic          sclQ;
  logic          sdaQ;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain[0] <= sclIn;
          sdaChain[0] <= sdaIn;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[LAST-1:0], sclIn};
          sdaChain <= {sdaChain[LAST-1:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclChain[LAST];
      sdaQ <= sdaChain[LAST];
    end
  end

  assign sclS     = sclChain[LAST];
  assign sdaS     = sdaChain[LAST];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet  = sclS & sclQ & ~sdaQ & sdaS;

endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclS,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic [7:0]  rxByte,
  output logic        shiftEn,
  output logic        ackDrive,
  output ctlStrobes_t ctl
);
  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam logic [3:0] ACK_SLOT      = 4'd9;

  phase_t     state;
  phase_t     nextState;
  logic [3:0] bitCnt;
  logic       active;
  logic       byteDone;
  logic       accept;

  assign active   = (state != ST_IDLE) && (state != ST_IGNORE);
  assign shiftEn  = active && sclRise && (bitCnt < BITS_PER_BYTE);
  assign byteDone = active && sclFall && (bitCnt == BITS_PER_BYTE);

  always_comb begin
    nextState = state;
    accept    = 1'b1;
    ctl       = '0;
    unique case (state)
      ST_ADDR: begin
        accept    = (rxByte[7:1] == DEV_ADDR) && !rxByte[0];
        nextState = accept ? ST_PTR : ST_IGNORE;
      end
      ST_PTR: begin
        ctl.loadPtr = byteDone;
        nextState   = isWide(rxByte) ? ST_MSB : ST_BYTE;
      end
      ST_MSB: begin
        ctl.loadMsb = byteDone;
        nextState   = ST_LSB;
      end
      ST_LSB: begin
        ctl.commitWide = byteDone;
        nextState      = ST_PTR;
      end
      ST_BYTE: begin
        ctl.commitNarrow = byteDone;
        nextState        = ST_PTR;
      end
      default: begin
        accept = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
    end else if (active) begin
      if (sclRise && (bitCnt < ACK_SLOT)) begin
        bitCnt <= bitCnt + 4'd1;
      end else if (sclFall && (bitCnt == ACK_SLOT)) begin
        bitCnt   <= '0;
        ackDrive <= 1'b0;
      end else if (byteDone) begin
        state    <= nextState;
        ackDrive <= accept;
      end
    end
  end

  // R7: nothing is acknowledged or committed while the transaction is ignored
  p_ignore_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> (!ackDrive && !ctl.commitWide && !ctl.commitNarrow));

  // R9: with no transaction open, SDA stays released
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !ackDrive);

  // R2: the acknowledge is only switched on while SCL is low
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> !sclS);

  // R3: a 16-bit data phase is always left through its second byte
  p_msb_to_lsb_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadMsb |=> (state == ST_LSB));

endmodule

// File: rtl/i2cw_dp.sv
module i2cw_dp
  import i2cw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdaS,
  input  logic        shiftEn,
  input  ctlStrobes_t ctl,
  output logic [7:0]  rxByte,
  output logic        wrStrobe,
  output logic [7:0]  wrAddr,
  output logic [15:0] wrData,
  output logic        wrWide
);
  logic [7:0] shiftReg;
  logic [7:0] ptrReg;
  logic [7:0] msbReg;

  assign rxByte = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ptrReg   <= '0;
      msbReg   <= '0;
    end else begin
      if (shiftEn) shiftReg <= {shiftReg[6:0], sdaS};
      if (ctl.loadPtr) ptrReg <= shiftReg;
      if (ctl.loadMsb) msbReg <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrWide   <= 1'b0;
    end else begin
      wrStrobe <= ctl.commitWide | ctl.commitNarrow;
      if (ctl.commitWide) begin
        wrAddr <= ptrReg;
        wrData <= {msbReg, shiftReg};
        wrWide <= 1'b1;
      end else if (ctl.commitNarrow) begin
        wrAddr <= ptrReg;
        wrData <= {8'h00, shiftReg};
        wrWide <= 1'b0;
      end
    end
  end

  // R4: a register write is a single-cycle pulse
  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R3: the width flag of a write agrees with the pointer it carries
  p_width_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrWide == isWide(wrAddr)));

  // R4: an 8-bit write never carries a non-zero upper byte
  p_narrow_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !wrWide) |-> (wrData[15:8] == 8'h00));

endmodule

// File: rtl/i2cw_top.sv
module i2cw_top
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaPullLow,
  output logic        wrStrobe,
  output logic [7:0]  wrAddr,
  output logic [15:0] wrData,
  output logic        wrWide
);
  logic        sclS;
  logic        sdaS;
  logic        sclRise;
  logic        sclFall;
  logic        startDet;
  logic        stopDet;
  logic        shiftEn;
  logic [7:0]  rxByte;
  ctlStrobes_t ctl;

  i2cw_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cw_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .shiftEn(shiftEn), .ackDrive(sdaPullLow), .ctl(ctl)
  );

  i2cw_dp u_dp (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .shiftEn(shiftEn), .ctl(ctl),
    .rxByte(rxByte), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .wrWide(wrWide)
  );

endmodule

// File: tb/sim_i2cw_top.sv
module sim_i2cw_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         HALF = 20;
  localparam int         QTR  = 10;
  localparam logic [6:0] DEV  = 7'h3A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic busSda;
  logic sdaPullLow, wrStrobe, wrWide;
  logic [7:0] wrAddr;
  logic [15:0] wrData;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] a; logic [15:0] d; logic w; } item_t;
  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign busSda = mSda & ~sdaPullLow;

  i2cw_top #(.DEV_ADDR(DEV)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda),
    .sdaPullLow(sdaPullLow), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .wrWide(wrWide)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectWrite(input logic [7:0] a, input logic [15:0] d, input logic w);
    item_t it;
    it.a = a; it.d = d; it.w = w;
    expQ.push_back(it);
  endtask

  // Monitor: pops the scoreboard on every strobe (R4, R5)
  always @(negedge clk) begin
    if (rstN && wrStrobe) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4/R6/R7: unexpected write addr=%h data=%h wide=%b, expected none",
                 wrAddr, wrData, wrWide);
      end else begin
        item_t e;
        e = expQ.pop_front();
        if (wrAddr !== e.a || wrData !== e.d || wrWide !== e.w) begin
          errors++;
          $display("FAIL R4/R5: write addr=%h data=%h wide=%b, expected addr=%h data=%h wide=%b",
                   wrAddr, wrData, wrWide, e.a, e.d, e.w);
        end
      end
    end
  end

  task automatic i2cStart;
    waitClk(QTR); mSda = 1'b1;
    waitClk(QTR); mScl = 1'b1;
    waitClk(HALF); mSda = 1'b0;
    waitClk(HALF); mScl = 1'b0;
  endtask

  task automatic i2cStop;
    waitClk(QTR); mSda = 1'b0;
    waitClk(QTR); mScl = 1'b1;
    waitClk(HALF); mSda = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic expAck, input string tag);
    logic seen;
    for (int i = 7; i >= 0; i--) begin
      waitClk(QTR); mSda = b[i];
      waitClk(QTR); mScl = 1'b1;
      waitClk(HALF); mScl = 1'b0;
    end
    waitClk(QTR); mSda = 1'b1;
    waitClk(QTR); mScl = 1'b1;
    waitClk(HALF/2);
    seen = ~busSda;
    checks++;
    if (seen !== expAck) begin
      errors++;
      $display("FAIL %s: ack on byte %h = %b, expected %b", tag, b, seen, expAck);
    end
    waitClk(HALF/2); mScl = 1'b0;
  endtask

  task automatic checkQueueEmpty(input string tag);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected writes missing, expected 0", tag, expQ.size());
    end
  endtask

  task automatic wideWrite(input logic [7:0] p, input logic [15:0] d);
    sendByte(p, 1'b1, "R2 pointer");
    sendByte(d[15:8], 1'b1, "R2 msb");
    expectWrite(p, d, 1'b1);
    sendByte(d[7:0], 1'b1, "R2 lsb");
  endtask

  task automatic narrowWrite(input logic [7:0] p, input logic [7:0] d);
    sendByte(p, 1'b1, "R2 pointer");
    expectWrite(p, {8'h00, d}, 1'b0);
    sendByte(d, 1'b1, "R2 data");
  endtask

  initial begin
    waitClk(5);
    // R9: reset state
    checks++;
    if (sdaPullLow !== 1'b0 || wrStrobe !== 1'b0) begin
      errors++;
      $display("FAIL R9: pull=%b strobe=%b, expected 0 0", sdaPullLow, wrStrobe);
    end
    rstN = 1'b1;
    waitClk(10);
    checks++;
    if (sdaPullLow !== 1'b0 || wrStrobe !== 1'b0) begin
      errors++;
      $display("FAIL R9: after release pull=%b strobe=%b, expected 0 0", sdaPullLow, wrStrobe);
    end

    // R1, R4: single wide write
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R1 address");
    wideWrite(8'h09, 16'hA55A);
    i2cStop;
    waitClk(20);
    checkQueueEmpty("R4 wide");

    // R3, R4: single narrow write
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R1 address");
    narrowWrite(8'h0A, 8'h3C);
    i2cStop;
    waitClk(20);
    checkQueueEmpty("R4 narrow");

    // R3, R5: chained writes across the width boundaries
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R1 address");
    wideWrite(8'h0B, 16'hABCD);
    narrowWrite(8'h05, 8'h7E);
    wideWrite(8'h25, 16'h1234);
    narrowWrite(8'h00, 8'h99);
    narrowWrite(8'h26, 8'h55);
    wideWrite(8'h01, 16'hFEDC);
    wideWrite(8'h04, 16'h0F0F);
    narrowWrite(8'h08, 8'hC3);
    i2cStop;
    waitClk(20);
    checkQueueEmpty("R3 R5 chain");

    // R6: stop after the first byte of a wide register
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R1 address");
    sendByte(8'h02, 1'b1, "R2 pointer");
    sendByte(8'hEE, 1'b1, "R2 msb");
    i2cStop;
    waitClk(40);
    checkQueueEmpty("R6 partial");
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R1 address");
    wideWrite(8'h02, 16'h6789);
    i2cStop;
    waitClk(20);
    checkQueueEmpty("R6 follow-up");

    // R7: wrong address ignores all following bytes
    i2cStart;
    sendByte({7'h3B, 1'b0}, 1'b0, "R1 mismatch");
    sendByte(8'h0A, 1'b0, "R7 ignored pointer");
    sendByte(8'h11, 1'b0, "R7 ignored data");
    sendByte({DEV, 1'b0}, 1'b0, "R7 ignored address-like byte");
    i2cStop;
    waitClk(20);

    // R1: read direction is not acknowledged
    i2cStart;
    sendByte({DEV, 1'b1}, 1'b0, "R1 read bit");
    sendByte(8'h0A, 1'b0, "R7 ignored after read");
    i2cStop;
    waitClk(20);
    checkQueueEmpty("R7 ignore");

    // R8: repeated start drops the partial wide value
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R1 address");
    sendByte(8'h03, 1'b1, "R2 pointer");
    sendByte(8'h44, 1'b1, "R2 msb");
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R8 address after restart");
    narrowWrite(8'h0A, 8'h66);
    // R8: restart after an ignored address recovers
    i2cStart;
    sendByte({7'h10, 1'b0}, 1'b0, "R1 mismatch");
    i2cStart;
    sendByte({DEV, 1'b0}, 1'b1, "R8 address after ignored");
    wideWrite(8'h03, 16'h2468);
    i2cStop;
    waitClk(40);
    checkQueueEmpty("R8 restart");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule